// File: doc/BRIEF.md
# Codec power-down and reset sequencer

This block holds the two control registers that power and reset the converter sections of an audio codec, along with the two per-channel output attenuation targets. From those registers it derives an enable for the ADC datapath and one for the DAC datapath. A shared reference enable overrides both. While the ADC is off, the ADC sample output is forced to zero. After the ADC comes back, the output stays zero for a fixed number of frame strobes. Only then do incoming samples pass.

On the DAC side, the block produces one attenuation level per channel. While the DAC is off, both levels are held at zero. Once it runs again, each level moves one code per frame strobe toward its programmed target. It follows that target if software changes it during the ramp.

Software reaches all four registers through a single-cycle write strobe and a combinational read port. Turning a section off never clears a register, and every register can still be written while a section is off.

Top module: `codec_pwr_seq`

## Requirements
- R1: After the synchronous active-low system reset, address 0 reads 0x07 and address 1 reads 0x00. Addresses 2 and 3 read 0x00. Both attenuation levels are 0, `adc_dout` is 0, `adc_mask_done` is 0, and both enables are 0.
- R2: The register map is as follows. Address 0 holds bit 0 = DAC power-on, bit 1 = ADC power-on, bit 2 = reference power-on. Address 1 holds bit 0 = DAC run and bit 1 = ADC run, where 0 means held in reset. Address 2 holds the left attenuation target and address 3 the right one. A write takes effect at the clock edge where `wr_en` is high, and `rdata` shows the register selected by `addr` in the same cycle.
- R3: Bits 7:3 of address 0 and bits 7:2 of address 1 ignore writes and always read 0. This includes the four-bit test field in bits 7:4 of address 0.
- R4: `adc_en` equals reference-on AND ADC power-on AND ADC run. `dac_en` equals reference-on AND DAC power-on AND DAC run. A 0 in the reference bit therefore stops both sections.
- R5: From the first clock edge at which `adc_en` is low, `adc_dout` is 0 and it stays 0 while `adc_en` stays low.
- R6: Once `adc_en` goes high, `adc_dout` stays 0 through 516 frame strobes. `adc_mask_done` rises at the edge that registers the 516th strobe. From the following edge, `adc_dout` is the registered `adc_din`.
- R7: A low `adc_en` clears the frame count and `adc_mask_done` at the next edge, including in the middle of a count. The full 516-strobe window then starts again.
- R8: From the first clock edge at which `dac_en` is low, both attenuation levels are 0 and they stay 0 while it is low.
- R9: While `dac_en` is high, each level changes only on a frame strobe. On each strobe it moves by exactly one code toward its target, and it holds once it equals the target.
- R10: If a target changes during a ramp, the level then steps toward the new target, downward if the new target is below the level.
- R11: Register contents are kept and remain writable while either section is powered down or held in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data of the addressed register |
| frame_stb | input | 1 | One-cycle pulse per LRCK frame |
| adc_din | input | 24 | ADC sample from the converter core |
| adc_dout | output | 24 | Gated ADC sample to the serial output stage |
| adc_mask_done | output | 1 | High once the post-wake zero window has ended |
| adc_en | output | 1 | ADC datapath enable |
| dac_en | output | 1 | DAC datapath enable |
| att_l | output | 8 | Left-channel attenuation level |
| att_r | output | 8 | Right-channel attenuation level |

## Verification
The register port is driven with patterns that set test and reserved bits together with functional bits. This separates stored bits from dropped bits. Each of the three enables is cleared on its own to show which one stops which section.

The zero window is counted in two ways. One run goes straight through. In the other, the ADC is reset after 300 strobes. Both runs must release on exactly the 516th strobe, so an off-by-one release or a count that survives a re-entry shows up. The ramp runs two channels with different targets, which exposes a level that jumps to its target, moves without a strobe, overshoots, or stops following a target lowered during the ramp.

// File: rtl/codec_pwr_pkg.sv
// Package: shared constants and types for the codec power/reset sequencer.
// Assumes the register map fits in a two-bit address space.
package codec_pwr_pkg;

    localparam int REG_DATA_W = 8;
    localparam int REG_ADDR_W = 2;
    localparam int NUM_CH     = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_PWR   = 2'd0,
        REG_RST   = 2'd1,
        REG_ATT_L = 2'd2,
        REG_ATT_R = 2'd3
    } reg_addr_e;

    // Power register stored bits, MSB first: reference, ADC, DAC.
    typedef struct packed {
        logic ref_on;
        logic adc_on;
        logic dac_on;
    } pwr_bits_t;

    // Reset register stored bits, MSB first: ADC run, DAC run.
    typedef struct packed {
        logic adc_run;
        logic dac_run;
    } rst_bits_t;

endpackage

// File: rtl/pwr_cfg_regs.sv
// Module: configuration register file for power, reset and attenuation targets.
// Assumes one write per cycle; reads are combinational; unused bits are not stored.
module pwr_cfg_regs
    import codec_pwr_pkg::*;
#(
    parameter int DATA_W = REG_DATA_W,
    parameter int ADDR_W = REG_ADDR_W,
    parameter int CH     = NUM_CH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output pwr_bits_t                   pwr_q,
    output rst_bits_t                   rst_q,
    output logic [CH-1:0][DATA_W-1:0]   target_q
);

    localparam int PWR_W = $bits(pwr_bits_t);
    localparam int RST_W = $bits(rst_bits_t);

    // Power register: only the three enables are kept; the test field is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwr_q <= '{ref_on: 1'b1, adc_on: 1'b1, dac_on: 1'b1};
        else if (wr_en && addr == ADDR_W'(REG_PWR))
            pwr_q <= pwr_bits_t'(wdata[PWR_W-1:0]);
    end

    // Reset register: both sections start held in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_q <= '0;
        else if (wr_en && addr == ADDR_W'(REG_RST))
            rst_q <= rst_bits_t'(wdata[RST_W-1:0]);
    end

    // One attenuation target register per channel, placed after the reset register.
    for (genvar c = 0; c < CH; c++) begin : g_target
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ATT_L) + ADDR_W'(c);

        // Stores the target for channel c.
        always_ff @(posedge clk) begin
            if (!rst_n)
                target_q[c] <= '0;
            else if (wr_en && addr == MY_ADDR)
                target_q[c] <= wdata;
        end

        AST_TARGET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == MY_ADDR) |=> (target_q[c] == $past(wdata))); // R2
    end

    // Read mux: unstored bits read as zero.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(REG_PWR):   rdata[PWR_W-1:0] = pwr_q;
            ADDR_W'(REG_RST):   rdata[RST_W-1:0] = rst_q;
            ADDR_W'(REG_ATT_L): rdata = target_q[0];
            default:            rdata = target_q[CH-1];
        endcase
    end

    AST_TEST_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(REG_PWR)) |-> (rdata[DATA_W-1:PWR_W] == '0)); // R3
    AST_RST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(REG_RST)) |-> (rdata[DATA_W-1:RST_W] == '0)); // R3

endmodule

// File: rtl/adc_wake_mask.sv
// Module: ADC output gate and post-wake zero window.
// Assumes frame_stb is a single-cycle pulse; the window restarts on any drop of adc_en.
module adc_wake_mask #(
    parameter int SAMPLE_W    = 24,
    parameter int MASK_FRAMES = 516
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adc_en,
    input  logic                frame_stb,
    input  logic [SAMPLE_W-1:0] adc_din,
    output logic [SAMPLE_W-1:0] adc_dout,
    output logic                mask_done
);

    localparam int                CNT_W    = $clog2(MASK_FRAMES + 1);
    localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(MASK_FRAMES - 1);

    logic [CNT_W-1:0] frame_cnt;

    // Counts frame strobes while enabled and flags the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !adc_en) begin
            frame_cnt <= '0;
            mask_done <= 1'b0;
        end else if (frame_stb && !mask_done) begin
            frame_cnt <= frame_cnt + 1'b1;
            if (frame_cnt == LAST_CNT)
                mask_done <= 1'b1;
        end
    end

    // Registers the sample, forcing zero when off or inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            adc_dout <= '0;
        else if (adc_en && mask_done)
            adc_dout <= adc_din;
        else
            adc_dout <= '0;
    end

    AST_ADC_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_en |=> (adc_dout == '0)); // R5
    AST_MASK_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_done |=> (adc_dout == '0)); // R6
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= CNT_W'(MASK_FRAMES)); // R6
    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_en |=> !mask_done); // R7

endmodule

// File: rtl/dac_att_ramp.sv
// Module: one channel's attenuation level, cleared when the DAC is off and ramped toward target.
// Assumes frame_stb is a single-cycle pulse; the target may change at any time.
module dac_att_ramp #(
    parameter int ATT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dac_en,
    input  logic             frame_stb,
    input  logic [ATT_W-1:0] target,
    output logic [ATT_W-1:0] level
);

    localparam logic [ATT_W-1:0] ONE = ATT_W'(1);

    // Clears while off, otherwise steps one code per frame toward the target.
    always_ff @(posedge clk) begin
        if (!rst_n || !dac_en)
            level <= '0;
        else if (frame_stb) begin
            if (level < target)
                level <= level + ONE;
            else if (level > target)
                level <= level - ONE;
        end
    end

    AST_LEVEL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_en |=> (level == '0)); // R8
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_en && !frame_stb) |=> $stable(level)); // R9
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_en && frame_stb && level < target) |=> (level == $past(level) + ONE)); // R9
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_en && frame_stb && level > target) |=> (level == $past(level) - ONE)); // R10

endmodule

// File: rtl/codec_pwr_seq.sv
// Module: top of the codec power-down and reset sequencer.
// Assumes a single clock domain and a synchronous active-low system reset.
module codec_pwr_seq
    import codec_pwr_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int MASK_FRAMES = 516,
    parameter int ATT_W       = REG_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [REG_DATA_W-1:0] wdata,
    output logic [REG_DATA_W-1:0] rdata,
    input  logic                  frame_stb,
    input  logic [SAMPLE_W-1:0]   adc_din,
    output logic [SAMPLE_W-1:0]   adc_dout,
    output logic                  adc_mask_done,
    output logic                  adc_en,
    output logic                  dac_en,
    output logic [ATT_W-1:0]      att_l,
    output logic [ATT_W-1:0]      att_r
);

    pwr_bits_t                          pwr_q;
    rst_bits_t                          rst_q;
    logic [NUM_CH-1:0][REG_DATA_W-1:0]  target_q;
    logic [NUM_CH-1:0][ATT_W-1:0]       level;

    pwr_cfg_regs #(
        .DATA_W (REG_DATA_W),
        .ADDR_W (REG_ADDR_W),
        .CH     (NUM_CH)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .pwr_q    (pwr_q),
        .rst_q    (rst_q),
        .target_q (target_q)
    );

    // Section enables: the reference bit gates both sections.
    always_comb begin
        adc_en = pwr_q.ref_on && pwr_q.adc_on && rst_q.adc_run;
        dac_en = pwr_q.ref_on && pwr_q.dac_on && rst_q.dac_run;
    end

    AST_REF_GATES_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[2] == 1'b0 && addr == REG_ADDR_W'(REG_PWR)) |-> (!adc_en && !dac_en)); // R4

    adc_wake_mask #(
        .SAMPLE_W    (SAMPLE_W),
        .MASK_FRAMES (MASK_FRAMES)
    ) adc_mask_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .adc_en    (adc_en),
        .frame_stb (frame_stb),
        .adc_din   (adc_din),
        .adc_dout  (adc_dout),
        .mask_done (adc_mask_done)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ramp
        dac_att_ramp #(
            .ATT_W (ATT_W)
        ) ramp_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .dac_en    (dac_en),
            .frame_stb (frame_stb),
            .target    (ATT_W'(target_q[c])),
            .level     (level[c])
        );
    end

    assign att_l = level[0];
    assign att_r = level[NUM_CH-1];

endmodule

// File: tb/codec_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module codec_pwr_seq_tb_top;

    localparam int MASK_N = 516;
    localparam logic [23:0] SAMPLE = 24'h123456;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        frame_stb = 1'b0;
    logic [23:0] adc_din = SAMPLE;
    logic [23:0] adc_dout;
    logic        adc_mask_done;
    logic        adc_en;
    logic        dac_en;
    logic [7:0]  att_l;
    logic [7:0]  att_r;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    codec_pwr_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .addr          (addr),
        .wdata         (wdata),
        .rdata         (rdata),
        .frame_stb     (frame_stb),
        .adc_din       (adc_din),
        .adc_dout      (adc_dout),
        .adc_mask_done (adc_mask_done),
        .adc_en        (adc_en),
        .dac_en        (dac_en),
        .att_l         (att_l),
        .att_r         (att_r)
    );

    // Vector: {addr, write data, expected read-back}
    localparam logic [17:0] VEC [0:9] = '{
        {2'd0, 8'hF5, 8'h05},
        {2'd0, 8'h0B, 8'h03},
        {2'd0, 8'h07, 8'h07},
        {2'd1, 8'hFF, 8'h03},
        {2'd1, 8'hFE, 8'h02},
        {2'd1, 8'h00, 8'h00},
        {2'd2, 8'h3C, 8'h3C},
        {2'd3, 8'hA5, 8'hA5},
        {2'd2, 8'h00, 8'h00},
        {2'd3, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_stb = 1'b1;
        @(posedge clk); #1;
        frame_stb = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        rd(2'd0, v); chk("R1 pwr reg", v, 8'h07);
        rd(2'd1, v); chk("R1 rst reg", v, 8'h00);
        rd(2'd2, v); chk("R1 left target", v, 8'h00);
        rd(2'd3, v); chk("R1 right target", v, 8'h00);
        chk("R1 att_l", att_l, 0);
        chk("R1 att_r", att_r, 0);
        chk("R1 adc_dout", adc_dout, 0);
        chk("R1 mask_done", adc_mask_done, 0);
        chk("R1 enables", {adc_en, dac_en}, 0);

        // R2 R3 R11: vector table, written while both sections are held in reset
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][17:16], VEC[i][15:8]);
            rd(VEC[i][17:16], v);
            chk("R2/R3/R11 table read-back", v, VEC[i][7:0]);
        end

        // R4: enable decode
        wr(2'd1, 8'h03);
        chk("R4 both run", {adc_en, dac_en}, 2'b11);
        wr(2'd0, 8'h03);
        chk("R4 reference off", {adc_en, dac_en}, 2'b00);
        wr(2'd0, 8'h05);
        chk("R4 ADC power off", {adc_en, dac_en}, 2'b01);
        wr(2'd0, 8'h06);
        chk("R4 DAC power off", {adc_en, dac_en}, 2'b10);
        wr(2'd0, 8'h07);
        chk("R4 all on", {adc_en, dac_en}, 2'b11);

        // R6: full zero window
        for (int i = 0; i < MASK_N - 1; i++) begin
            frame();
            chk("R6 masked output", adc_dout, 0);
        end
        chk("R6 done before last strobe", adc_mask_done, 0);
        frame();
        chk("R6 done at 516th strobe", adc_mask_done, 1);
        chk("R6 output still zero", adc_dout, 0);
        tick();
        chk("R6 sample passes", adc_dout, SAMPLE);

        // R5: ADC reset forces the output low
        wr(2'd1, 8'h01);
        tick();
        chk("R5 output low in reset", adc_dout, 0);
        chk("R7 done cleared", adc_mask_done, 0);

        // R7: restart during a count
        wr(2'd1, 8'h03);
        for (int i = 0; i < 300; i++) frame();
        chk("R7 mid-count not done", adc_mask_done, 0);
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h03);
        for (int i = 0; i < MASK_N - 1; i++) frame();
        chk("R7 restarted window not done", adc_mask_done, 0);
        chk("R7 restarted output zero", adc_dout, 0);
        frame();
        chk("R7 done after full window", adc_mask_done, 1);
        tick();
        chk("R7 sample passes", adc_dout, SAMPLE);

        // R9: ramp toward targets
        wr(2'd2, 8'd5);
        wr(2'd3, 8'd2);
        chk("R9 no move without strobe", {att_l, att_r}, 16'h0000);
        frame(); chk("R9 step 1", {att_l, att_r}, {8'd1, 8'd1});
        frame(); chk("R9 step 2", {att_l, att_r}, {8'd2, 8'd2});
        frame(); chk("R9 step 3 right holds", {att_l, att_r}, {8'd3, 8'd2});
        frame(); frame();
        chk("R9 left reaches target", {att_l, att_r}, {8'd5, 8'd2});
        frame();
        chk("R9 hold at target", {att_l, att_r}, {8'd5, 8'd2});
        repeat (3) tick();
        chk("R9 stable without strobe", att_l, 8'd5);

        // R10: target changes during the ramp
        wr(2'd2, 8'd8);
        frame(); chk("R10 up toward new target", att_l, 8'd6);
        wr(2'd2, 8'd3);
        frame(); chk("R10 down step 1", att_l, 8'd5);
        frame(); chk("R10 down step 2", att_l, 8'd4);
        frame(); chk("R10 down step 3", att_l, 8'd3);
        frame(); chk("R10 hold at lowered target", att_l, 8'd3);

        // R8: DAC reset clears levels; R11: target writable while off
        wr(2'd1, 8'h02);
        tick();
        chk("R8 levels cleared in reset", {att_l, att_r}, 16'h0000);
        wr(2'd2, 8'd7);
        rd(2'd2, v); chk("R11 target write while off", v, 8'd7);
        frame(); frame();
        chk("R8 stays cleared with strobes", {att_l, att_r}, 16'h0000);
        wr(2'd1, 8'h03);
        frame(); frame(); frame();
        chk("R9 fade-in after exit", {att_l, att_r}, {8'd3, 8'd2});
        wr(2'd0, 8'h06);
        tick();
        chk("R8 levels cleared in power-down", {att_l, att_r}, 16'h0000);
        rd(2'd3, v); chk("R11 right target kept", v, 8'd2);

        finish_run();
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule